// File: doc/BRIEF.md
# Byte-Lane Gated Register Write Bridge

This bridge sits on the slave side of a 32-bit memory-mapped register bus and forwards writes into a small byte-writable register file. The bus has no byte strobes. Lane selection is therefore held in a separate write-control register. Software loads this register with a lane mask and then issues the data write. Every later write into the target window updates only the bytes whose lane is enabled. Bytes in disabled lanes keep their earlier contents.

A 32-bit store uses the all-lanes control word 0x78. A 16-bit store at byte offset m uses `(2'b11 << m) << 3`, and an 8-bit store uses `(1 << m) << 3`. The mask stays in force until software rewrites the control word. Software must keep the control write and its data write together as an uninterrupted pair. Reads do not use the mask. They return whole words.

Top module: `byte_lane_wr_bridge`

## Requirements
- R1: After reset the control register reads 0x78, which enables all four lanes, and every target word reads zero.
- R2: A write to the control address (byte 0x40) stores bits 6:3 of the write data as the lane mask, with bit 3 for lane 0 (data bits 7:0) up to bit 6 for lane 3 (data bits 31:24). A read of the control address returns the mask in bits 6:3, and all other bits read as zero.
- R3: A write to a target word (byte addresses 0x00 to 0x1C, word index = address bits 4:2, address bits 1:0 ignored) loads each byte whose lane bit is set from the write data. Each byte whose lane bit is clear keeps its old value.
- R4: The lane mask applies to every following target write, including writes to different words, until the control register is written again.
- R5: A read of a target word returns all 32 bits of its contents, whatever the current lane mask.
- R6: A mask written in one cycle governs a target write issued in the very next cycle.
- R7: Read data is combinational from the current address. A read of a word in the cycle that writes it returns the pre-write value, and the new value is visible from the following cycle. This holds for the control register as well as for the target words.
- R8: Writes to addresses outside both windows change neither the mask nor any target word. Reads of such addresses return zero.
- R9: With an all-zero lane mask, target writes leave the target words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe; a write happens on each rising edge where it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Two pairs of events can share a cycle. The first pair is a write and a read of the same word. The second pair is a control update and a data write in back-to-back cycles. The bench drives a write while it samples read data just before the clock edge, and it expects the value from before the write. It then issues a lane-mask change followed at once by a target write, and it judges the result by reading the word back in full. Only the byte in the newly enabled lane may have changed.

// File: rtl/blw_pkg.sv
package blw_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_CTRL = 2'd1,
      WIN_TGT  = 2'd2
   } win_sel_e;
endpackage

// File: rtl/blw_decode.sv
module blw_decode
   import blw_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BOFF      = 2,
   parameter int TGT_BASE  = 0,
   parameter int NUM_REGS  = 8,
   parameter int CTRL_ADDR = 'h40,
   parameter int IDX_W     = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output win_sel_e          sel,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] TGT_A  = ADDR_W'(TGT_BASE);
   localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);

   logic [ADDR_W-1:0] off;
   logic [ADDR_W-1:0] word_off;
   logic              ctrl_hit;
   logic              tgt_hit;

   assign off      = addr - TGT_A;
   assign word_off = off >> BOFF;
   assign ctrl_hit = (addr[ADDR_W-1:BOFF] == CTRL_A[ADDR_W-1:BOFF]);
   assign tgt_hit  = (addr >= TGT_A) && (word_off < NREG_A);
   assign idx      = word_off[IDX_W-1:0];

   always_comb begin
      if (ctrl_hit)     sel = WIN_CTRL;
      else if (tgt_hit) sel = WIN_TGT;
      else              sel = WIN_NONE;
   end
endmodule

// File: rtl/blw_lane_ctrl.sv
module blw_lane_ctrl #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LANES-1:0] wr_mask,
   output logic [LANES-1:0] mask_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     mask_q <= '1;
      else if (wr_en) mask_q <= wr_mask;
   end
endmodule

// File: rtl/blw_reg_file.sv
module blw_reg_file #(
   parameter int DATA_W   = 32,
   parameter int LANES    = 4,
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [LANES-1:0]           wr_lanes,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      logic word_sel;
      assign word_sel = wr_en && (wr_idx == IDX_W'(r));
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [7:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                       byte_q <= '0;
            else if (word_sel && wr_lanes[l]) byte_q <= wdata[l*8 +: 8];
         end
         assign regs_flat[r*DATA_W + l*8 +: 8] = byte_q;
      end
   end
endmodule

// File: rtl/byte_lane_wr_bridge.sv
module byte_lane_wr_bridge
   import blw_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 8,
   parameter int TGT_BASE  = 'h00,
   parameter int CTRL_ADDR = 'h40,
   parameter int MASK_LSB  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int BOFF  = $clog2(LANES);
   localparam int IDX_W = $clog2(NUM_REGS);

   if (DATA_W % 8 != 0 || (1 << BOFF) != LANES) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (MASK_LSB + LANES > DATA_W) begin : g_bad_mask
      $error("lane mask field does not fit in the data word");
   end
   if (NUM_REGS < 2) begin : g_bad_depth
      $error("NUM_REGS must be at least 2");
   end
   if (TGT_BASE % LANES != 0 || CTRL_ADDR % LANES != 0) begin : g_bad_align
      $error("window addresses must be word aligned");
   end

   win_sel_e                   sel;
   logic [IDX_W-1:0]           idx;
   logic [LANES-1:0]           mask_q;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;
   logic [DATA_W-1:0]          ctrl_word;

   blw_decode #(
      .ADDR_W(ADDR_W), .BOFF(BOFF), .TGT_BASE(TGT_BASE),
      .NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR), .IDX_W(IDX_W)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel),
      .idx  (idx)
   );

   blw_lane_ctrl #(.LANES(LANES)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we && (sel == WIN_CTRL)),
      .wr_mask (bus_wdata[MASK_LSB +: LANES]),
      .mask_q  (mask_q)
   );

   blw_reg_file #(
      .DATA_W(DATA_W), .LANES(LANES), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_we && (sel == WIN_TGT)),
      .wr_idx    (idx),
      .wr_lanes  (mask_q),
      .wdata     (bus_wdata),
      .regs_flat (regs_flat)
   );

   assign ctrl_word = DATA_W'(mask_q) << MASK_LSB;

   always_comb begin
      case (sel)
         WIN_CTRL: bus_rdata = ctrl_word;
         WIN_TGT:  bus_rdata = regs_flat[idx*DATA_W +: DATA_W];
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/byte_lane_wr_bridge_chk.sv
module byte_lane_wr_bridge_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 8,
   parameter int TGT_BASE  = 'h00,
   parameter int CTRL_ADDR = 'h40,
   parameter int MASK_LSB  = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic                       bus_we,
   input logic [DATA_W-1:0]          bus_rdata,
   input logic [DATA_W/8-1:0]        lane_mask,
   input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   localparam int LANES = DATA_W / 8;
   localparam int BOFF  = $clog2(LANES);
   localparam int IDX_W = $clog2(NUM_REGS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] TGT_A  = ADDR_W'(TGT_BASE);
   localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);
   localparam logic [DATA_W-1:0] FIELD  = DATA_W'({LANES{1'b1}}) << MASK_LSB;

   logic [ADDR_W-1:0] woff;
   logic              c_hit;
   logic              t_hit;
   logic [IDX_W-1:0]  t_idx;
   logic              wr_tgt;

   assign woff   = (bus_addr - TGT_A) >> BOFF;
   assign c_hit  = bus_addr[ADDR_W-1:BOFF] == CTRL_A[ADDR_W-1:BOFF];
   assign t_hit  = !c_hit && (bus_addr >= TGT_A) && (woff < NREG_A);
   assign t_idx  = woff[IDX_W-1:0];
   assign wr_tgt = bus_we && t_hit;

   p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lane_mask == '1 && regs_flat == '0));

   p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && c_hit) |=> lane_mask == $past(bus_wdata[MASK_LSB +: LANES]));

   p_ctrl_rd_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      c_hit |-> (bus_rdata & ~FIELD) == '0);

   p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && c_hit) |=> $stable(lane_mask));

   p_tgt_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      t_hit |-> bus_rdata == regs_flat[t_idx*DATA_W +: DATA_W]);

   p_stray_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !c_hit && !t_hit) |=> ($stable(regs_flat) && $stable(lane_mask)));

   p_stray_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_hit && !t_hit) |-> bus_rdata == '0);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_w
      for (genvar l = 0; l < LANES; l++) begin : g_l
         p_lane_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_tgt && t_idx == IDX_W'(r) && lane_mask[l]) |=>
               regs_flat[r*DATA_W + l*8 +: 8] == $past(bus_wdata[l*8 +: 8]));
         p_lane_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_tgt && t_idx == IDX_W'(r) && lane_mask[l]) |=>
               $stable(regs_flat[r*DATA_W + l*8 +: 8]));
      end
   end
endmodule

bind byte_lane_wr_bridge byte_lane_wr_bridge_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
   .TGT_BASE(TGT_BASE), .CTRL_ADDR(CTRL_ADDR), .MASK_LSB(MASK_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .lane_mask (mask_q),
   .regs_flat (regs_flat)
);

// File: tb/byte_lane_wr_bridge_tb.sv
module byte_lane_wr_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;

   byte_lane_wr_bridge u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata)
   );

   // driver: one bus cycle per call, inputs change on the falling edge
   task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input bit chk, input logic [31:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      bus_we    = we;
      bus_addr  = a;
      bus_wdata = d;
      if (chk) begin
         it.exp = exp;
         it.tag = tag;
         sb_q.push_back(it);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0, '0, "");
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      cyc(1'b0, a, '0, 1'b1, exp, tag);
   endtask

   // monitor: samples read data 1 ns before the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (bus_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(8'h40, 32'h0000_0078, "R1 ctrl reset");
      rd(8'h00, 32'h0, "R1 word0 reset");
      rd(8'h1C, 32'h0, "R1 word7 reset");
      // R2 mask field only
      wr(8'h40, 32'hFFFF_FFFF);
      rd(8'h40, 32'h0000_0078, "R2 field bits only");
      wr(8'h40, 32'h0000_0050);
      rd(8'h40, 32'h0000_0050, "R2 lanes 1,3");
      wr(8'h40, 32'hFFFF_FF87);
      rd(8'h40, 32'h0, "R2 zero mask");
      // R9 zero mask blocks writes
      wr(8'h04, 32'hDEAD_BEEF);
      rd(8'h04, 32'h0, "R9 no lanes");
      // full word
      wr(8'h40, 32'h78);
      wr(8'h04, 32'h1122_3344);
      rd(8'h04, 32'h1122_3344, "R3 full word");
      wr(8'h1C, 32'hCAFE_F00D);
      rd(8'h1C, 32'hCAFE_F00D, "R3 last word");
      // R3 single byte, lane 2
      wr(8'h40, 32'h20);
      wr(8'h04, 32'hAABB_CCDD);
      rd(8'h04, 32'h11BB_3344, "R3 lane2 only");
      // R4 sticky mask
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, 32'h00FF_0000, "R4 sticky other word");
      wr(8'h06, 32'h0);
      rd(8'h04, 32'h1100_3344, "R4 sticky same word");
      // halfword at offset 2, read ignores mask
      wr(8'h40, 32'h60);
      wr(8'h06, 32'h5566_0000);
      rd(8'h04, 32'h5566_3344, "R5 full read, halfword mask");
      // R6 mask then data in next cycle
      wr(8'h40, 32'h08);
      wr(8'h0C, 32'hA1B2_C3D4);
      rd(8'h0C, 32'h0000_00D4, "R6 back-to-back");
      // R7 read during write
      cyc(1'b1, 8'h0C, 32'h0000_00EE, 1'b1, 32'h0000_00D4, "R7 old value in write cycle");
      rd(8'h0C, 32'h0000_00EE, "R7 new value next cycle");
      cyc(1'b1, 8'h40, 32'h78, 1'b1, 32'h0000_0008, "R7 ctrl old value");
      rd(8'h40, 32'h0000_0078, "R7 ctrl new value");
      // R8 unmapped
      wr(8'h20, 32'h1234_5678);
      wr(8'h44, 32'h0);
      rd(8'h20, 32'h0, "R8 read past window");
      rd(8'h44, 32'h0, "R8 read beside ctrl");
      rd(8'h40, 32'h0000_0078, "R8 mask untouched");
      rd(8'h0C, 32'h0000_00EE, "R8 word untouched");
      rd(8'h1C, 32'hCAFE_F00D, "R8 last word untouched");
      cyc(1'b0, 8'h00, '0, 1'b0, '0, "");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule